// File: doc/BRIEF.md
# Inline SECDED Read-Data Corrector

This block sits on the read-data path of a cache data array whose 64-bit words are stored as 72-bit SECDED codewords. Each incoming codeword is checked on the fly. A word with no error, or one with an error it cannot fix, leaves in the same cycle it arrives, so clean traffic sees no extra latency.

A word with a single flipped bit is held back instead. In the cycle it is accepted, the block finds the faulty bit from the syndrome. In the next cycle it flips that bit and registers the result. The repaired word is then offered with a correction flag and a request to evict its line. While this happens the input is not ready, so the stream stalls for exactly two cycles and then resumes.

Both sides use valid/ready handshakes. A word moves when valid and ready are both high at a rising clock edge.

Top module: `secded_read_fix`

## Requirements
- R1: A clean codeword (all check relations satisfied, overall parity even) is presented on the output in the same cycle it is offered. out_valid equals in_valid, in_ready equals out_ready, out_data holds the data bits, and out_corr, out_uncorr and out_evict are 0.
- R2: Codeword layout. Bit 0 is the overall parity bit, chosen so that all 72 bits XOR to 0. Bits 1 to 71 are Hamming positions 1 to 71. Check bit k sits at position 2^k (positions 1, 2, 4, 8, 16, 32, 64) and makes the XOR of every position with bit k set equal to 0. Data bit j sits at the j-th non-power-of-two position, counted upward from position 3.
- R3: A codeword with one data bit flipped is delivered with that bit restored, out_corr=1, out_evict=1 and out_uncorr=0.
- R4: If a single-error word is accepted in cycle N, then out_valid is 0 in cycles N and N+1 and the corrected word is valid from cycle N+2. in_ready stays 0 from cycle N+1 until the corrected word has been taken.
- R5: A codeword whose only flipped bit is a check bit or the overall parity bit takes the same two-cycle path and raises out_corr=1 and out_evict=1. Its data bits are delivered unchanged.
- R6: A codeword with two flipped bits is passed through with no stall. It carries out_uncorr=1, out_corr=0 and out_evict=0, and out_data holds the received data bits as they are.
- R7: A codeword with odd overall parity whose syndrome points past position 71 is treated as uncorrectable. It is handled exactly as in R6.
- R8: While a corrected word is held and out_ready is 0, the output stays valid and out_data and the flags do not change. Once the word is taken, the block returns to pass-through mode with in_ready following out_ready.
- R9: After synchronous reset no corrected word is pending: out_valid follows in_valid and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input codeword is present |
| in_ready | output | 1 | Block can take a codeword this cycle |
| in_code | input | 72 | Received codeword (layout per R2) |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | 64 | Delivered data word |
| out_corr | output | 1 | A single-bit error was corrected in this word |
| out_uncorr | output | 1 | This word has an error that could not be corrected |
| out_evict | output | 1 | The line holding this word should be evicted |

## Verification
The bench builds the block with its default width of 64 data bits. That gives 7 check bits and 71 Hamming positions, which leaves syndrome values 72 to 127 unused. A triple error made of check bits 64, 8 and 1 produces one of those values, so the out-of-range case of R7 can be reached. A sweep of single errors over all 72 bit positions covers both the data-bit and check-bit correction paths. Random words mix clean, single-error and double-error codewords with random back-pressure during the hold.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Smallest number of Hamming check bits that covers dw data bits.
  function automatic int chk_bits(input int dw);
    int r;
    r = 0;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Hamming position of data bit j: the j-th position that is not a power of two.
  function automatic int data_pos(input int j);
    int p;
    int cnt;
    p   = 0;
    cnt = -1;
    while (cnt < j) begin
      p++;
      if ((p & (p - 1)) != 0) cnt++;
    end
    return p;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIX  = 2'd1,
    ST_HOLD = 2'd2
  } rd_state_t;

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P_W  = chk_bits(DATA_W),
  localparam int HW   = DATA_W + P_W,
  localparam int CW_W = HW + 1
) (
  input  logic [CW_W-1:0] cw,
  output logic [P_W-1:0]  syn,
  output logic            par_odd
);

  always_comb begin
    syn = '0;
    for (int i = 1; i <= HW; i++) begin
      for (int k = 0; k < P_W; k++) begin
        if (((i >> k) & 1) != 0) syn[k] = syn[k] ^ cw[i];
      end
    end
  end

  assign par_odd = ^cw;

endmodule

// File: rtl/secded_extract.sv
module secded_extract
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P_W  = chk_bits(DATA_W),
  localparam int CW_W = DATA_W + P_W + 1
) (
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data
);

  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    localparam int POS = data_pos(j);
    assign data[j] = cw[POS];
  end

endmodule

// File: rtl/secded_locate.sv
module secded_locate
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P_W = chk_bits(DATA_W)
) (
  input  logic [P_W-1:0]    syn,
  output logic [DATA_W-1:0] flip
);

  // A syndrome that names a check-bit position matches no data bit.
  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    localparam int POS = data_pos(j);
    localparam logic [P_W-1:0] POS_V = POS[P_W-1:0];
    assign flip[j] = (syn == POS_V);
  end

endmodule

// File: rtl/secded_read_fix.sv
module secded_read_fix
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P_W  = chk_bits(DATA_W),
  localparam int HW   = DATA_W + P_W,
  localparam int CW_W = HW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CW_W-1:0]   in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_corr,
  output logic              out_uncorr,
  output logic              out_evict
);

  logic [P_W-1:0]    syn;
  logic              par_odd;
  logic [DATA_W-1:0] raw_data;
  logic [DATA_W-1:0] flip;

  secded_syndrome #(.DATA_W(DATA_W)) u_syn (.cw(in_code), .syn(syn), .par_odd(par_odd));
  secded_extract  #(.DATA_W(DATA_W)) u_ext (.cw(in_code), .data(raw_data));
  secded_locate   #(.DATA_W(DATA_W)) u_loc (.syn(syn), .flip(flip));

  logic clean_in, single_in, uncorr_in;
  assign clean_in  = (syn == '0) && !par_odd;
  assign single_in = par_odd && (int'(syn) <= HW);
  assign uncorr_in = !clean_in && !single_in;

  rd_state_t         state;
  logic [DATA_W-1:0] raw_r;
  logic [DATA_W-1:0] flip_r;
  logic [DATA_W-1:0] hold_r;
  logic              accept;
  logic              idle;
  logic              held;

  assign idle     = (state == ST_IDLE);
  assign held     = (state == ST_HOLD);
  assign in_ready = idle && out_ready;
  assign accept   = in_valid && in_ready;

  // Control state, reset synchronously.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept && single_in) state <= ST_FIX;
        ST_FIX:  state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Data path registers: locate at acceptance, flip one cycle later.
  always_ff @(posedge clk) begin
    if (idle && accept && single_in) begin
      raw_r  <= raw_data;
      flip_r <= flip;
    end
    if (state == ST_FIX) hold_r <= raw_r ^ flip_r;
  end

  assign out_valid  = held || (idle && in_valid && !single_in);
  assign out_data   = held ? hold_r : raw_data;
  assign out_corr   = held;
  assign out_evict  = held;
  assign out_uncorr = idle && in_valid && uncorr_in;

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (idle && in_valid && clean_in) |-> (out_valid && !out_corr && !out_uncorr && out_data == raw_data)) // R1
    else $error("clean word not passed through");

  AST_CORR_GAP: assert property (@(posedge clk) disable iff (rst)
    (accept && single_in) |=> (!out_valid && !in_ready)) // R4
    else $error("output or input open during correction");

  AST_CORR_ARRIVE: assert property (@(posedge clk) disable iff (rst)
    (accept && single_in) |-> ##2 (out_valid && out_corr && out_evict)) // R4
    else $error("corrected word not delivered after two cycles");

  AST_FIX_ONEBIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |-> $onehot0(flip_r)) // R5
    else $error("more than one data bit selected for correction");

  AST_UNCORR_NOSTALL: assert property (@(posedge clk) disable iff (rst)
    (accept && uncorr_in) |=> (state == ST_IDLE)) // R6
    else $error("uncorrectable word stalled the stream");

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (out_corr && !out_ready) |=> (out_valid && out_corr && $stable(out_data))) // R8
    else $error("held corrected word changed");

endmodule

// File: tb/sim_secded_read_fix.sv
module sim_secded_read_fix;
  localparam int CLK_P = 10;
  localparam int D     = 64;
  localparam int PW    = 7;
  localparam int HW    = D + PW;
  localparam int CW    = HW + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [CW-1:0] in_code;
  logic          out_valid;
  logic          out_ready;
  logic [D-1:0]  out_data;
  logic          out_corr;
  logic          out_uncorr;
  logic          out_evict;

  int n_tot  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  secded_read_fix #(.DATA_W(D)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_corr(out_corr), .out_uncorr(out_uncorr), .out_evict(out_evict)
  );

  // Build a codeword from the layout in R2.
  function automatic logic [CW-1:0] enc(input logic [D-1:0] d);
    logic [CW-1:0] c;
    logic b;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= HW; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < PW; k++) begin
      b = 1'b0;
      for (int p = 1; p <= HW; p++) if (((p >> k) & 1) != 0) b = b ^ c[p];
      c[1 << k] = b;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic logic [D-1:0] raw(input logic [CW-1:0] c);
    logic [D-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= HW; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p];
        j++;
      end
    end
    return d;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [4:0] stat();
    return {out_valid, in_ready, out_corr, out_uncorr, out_evict};
  endfunction

  // kind: 0 clean, 1 single error, 2 uncorrectable. bp: cycles of back-pressure on a held word.
  task automatic run_word(input logic [CW-1:0] c, input logic [D-1:0] exp_d, input int kind,
                          input int bp, input string rq);
    logic [4:0] st;
    @(negedge clk);
    in_valid  = 1'b1;
    in_code   = c;
    out_ready = 1'b1;
    #1;
    st = stat();
    if (kind == 0) begin
      chk(st == 5'b11000, rq, 64'(st), 64'(5'b11000));
      chk(out_data == exp_d, rq, out_data, exp_d);
    end else if (kind == 2) begin
      chk(st == 5'b11010, rq, 64'(st), 64'(5'b11010));
      chk(out_data == exp_d, rq, out_data, exp_d);
    end else begin
      chk(st == 5'b01000, {rq, " R4 cycle N"}, 64'(st), 64'(5'b01000));
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_code  = ~c;
    if (kind == 1) begin
      #1;
      st = stat();
      chk(st == 5'b00000, {rq, " R4 cycle N+1"}, 64'(st), 64'(5'b00000));
      @(negedge clk);
      out_ready = (bp == 0);
      #1;
      st = stat();
      chk(st == 5'b10101, {rq, " R4 cycle N+2"}, 64'(st), 64'(5'b10101));
      chk(out_data == exp_d, rq, out_data, exp_d);
      for (int i = 0; i < bp; i++) begin
        @(negedge clk);
        #1;
        st = stat();
        chk(st == 5'b10101 && out_data == exp_d, "R8 hold", out_data, exp_d);
      end
      out_ready = 1'b1;
      @(negedge clk);
      #1;
      st = stat();
      chk(st == 5'b01000, "R8 release", 64'(st), 64'(5'b01000));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_tot++;
      n_fail++;
      $display("FAIL R4 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    logic [D-1:0]  d;
    logic [CW-1:0] c;
    logic [CW-1:0] e;
    void'($urandom(32'h5EC0DE));
    rst       = 1'b1;
    in_valid  = 1'b0;
    in_code   = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(stat() == 5'b01000, "R9 reset idle", 64'(stat()), 64'(5'b01000));
    out_ready = 1'b0;
    #1;
    chk(stat() == 5'b00000, "R9 ready follows", 64'(stat()), 64'(5'b00000));
    out_ready = 1'b1;

    // Directed clean words.
    run_word(enc('0), '0, 0, 0, "R1 zero");
    run_word(enc('1), '1, 0, 0, "R1 ones");
    run_word(enc(64'hA5A5_0F0F_1234_8001), 64'hA5A5_0F0F_1234_8001, 0, 0, "R2 layout");

    // Single error at every bit position.
    d = 64'hDEAD_BEEF_0123_4567;
    for (int p = 0; p < CW; p++) begin
      c = enc(d);
      c[p] = ~c[p];
      if (p == 0 || (p & (p - 1)) == 0) run_word(c, d, 1, p % 3, "R5 check-bit error");
      else run_word(c, d, 1, p % 3, "R3 data-bit error");
    end

    // Double errors.
    c = enc(d);
    c[3] = ~c[3];
    c[70] = ~c[70];
    run_word(c, raw(c), 2, 0, "R6 double data");
    c = enc(d);
    c[0] = ~c[0];
    c[5] = ~c[5];
    run_word(c, raw(c), 2, 0, "R6 parity+data");

    // Syndrome 73 with odd parity: past the last position.
    c = enc(d);
    c[64] = ~c[64];
    c[8] = ~c[8];
    c[1] = ~c[1];
    run_word(c, raw(c), 2, 0, "R7 out of range");

    // Random mix.
    for (int n = 0; n < 300; n++) begin
      int kind;
      int p1;
      int p2;
      d    = rnd64();
      kind = int'($urandom() % 3);
      e    = enc(d);
      if (kind == 0) begin
        run_word(e, d, 0, 0, "R1 random clean");
      end else if (kind == 1) begin
        p1 = int'($urandom() % CW);
        e[p1] = ~e[p1];
        run_word(e, d, 1, int'($urandom() % 3), "R3 random single");
      end else begin
        p1 = int'($urandom() % CW);
        p2 = (p1 + 1 + int'($urandom() % (CW - 1))) % CW;
        e[p1] = ~e[p1];
        e[p2] = ~e[p2];
        run_word(e, raw(e), 2, 0, "R6 random double");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

endmodule